// File: doc/BRIEF.md
# Ramp Converter Conversion Sequencer

This block is the digital half of a single-slope (ramp) analog-to-digital converter. A one-cycle start request launches a conversion. The block holds the integrator capacitor shorted for a minimum number of clocks and clears its tick counter. On one clock edge it then removes the short, enables the ramp drive and begins counting clocks. It stops counting when the comparator reports, through a synchronizer, that the ramp has passed the input voltage.

The elapsed tick count is the raw measurement. It is proportional to the input voltage. The block scales it to an unsigned code of `CODE_W` bits, taking `FULL_TICKS` as the count at full-scale input. For example, a 1 V/ms ramp counted at 10 kHz against a 5 V full scale gives `FULL_TICKS` = 50, and a 2.5 V input then yields 25 ticks and code 7. When the count reaches full scale before any comparator edge, the conversion ends with the top code and an overrange flag. Each result comes with a one-cycle done pulse and stays on the outputs until the next conversion completes.

Top module: `ramp_conv_ctrl`

## Requirements
- R1: After reset, `discharge_o`=1, `ramp_en_o`=0, `busy_o`=0, `done_o`=0, and `code_o`, `raw_o` and `overrange_o` are all 0.
- R2: A `start_i` high at a clock edge while idle makes `busy_o` high. `discharge_o` then stays high and `ramp_en_o` low for exactly `DISCH_CYCLES` clock cycles, and the tick counter is cleared to zero during that time.
- R3: `discharge_o` falls and `ramp_en_o` rises on the same clock edge, and the tick count starts from zero at that edge.
- R4: While the ramp runs, the count grows by one per clock. `cmp_i` passes through `SYNC_STAGES` flip-flops, and only a rising edge of the synchronized level stops the count. If `cmp_i` goes high in the m-th cycle after the ramp release (m=0 is the first ramp cycle) and stays high, `raw_o` = m + `SYNC_STAGES`.
- R5: On a comparator stop, `code_o` = floor(`raw_o` × (2^`CODE_W` − 1) / `FULL_TICKS`), saturated at 2^`CODE_W` − 1, and `overrange_o` = 0.
- R6: If the count reaches `FULL_TICKS` with no synchronized comparator edge at that edge, the conversion ends with `raw_o` = `FULL_TICKS`, `code_o` all ones and `overrange_o` = 1. A comparator edge at the same edge takes precedence and gives `overrange_o` = 0.
- R7: `done_o` is high for exactly one cycle per conversion. On the edge where it rises, `busy_o` falls and `discharge_o` returns high.
- R8: `code_o`, `raw_o` and `overrange_o` change only on the edge that raises `done_o`. They hold their values through the whole of the next conversion.
- R9: `start_i` has no effect while `busy_o` is high, whether during discharge or during the ramp.
- R10: A rising edge on `cmp_i` while no ramp is running is ignored. It does not end the conversion that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count tick per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_i | input | 1 | Comparator output, asynchronous, high once the ramp exceeds the input |
| discharge_o | output | 1 | Shorts the integrator capacitor |
| ramp_en_o | output | 1 | Enables the integrator drive |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result strobe |
| code_o | output | CODE_W | Scaled output code |
| raw_o | output | CNT_W | Captured tick count |
| overrange_o | output | 1 | Full scale reached without a comparator edge |

## Verification
A table of input voltages is converted into the comparator edge times a ramp would produce. The table covers a crossing in the very first ramp cycle, mid-scale points whose scaled code truncates a large fraction, and a crossing that lands exactly on the full-scale count. These separate an off-by-one in the synchronizer latency from one in the scaling. A run with no crossing, and one whose crossing falls a single tick beyond full scale, tell timeout from a late comparator stop. Directed runs add a comparator glitch during discharge and start requests during discharge and during the ramp, which a design that samples its inputs outside the ramp state would act on.

// File: rtl/ramp_conv_pkg.sv
package ramp_conv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DISCH = 2'd1,
      ST_RAMP  = 2'd2
   } conv_state_t;

endpackage

// File: rtl/ramp_cmp_sync.sv
module ramp_cmp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ramp_tick_cnt.sv
module ramp_tick_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             en_i,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else if (en_i)    cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/ramp_code_scale.sv
module ramp_code_scale #(
   parameter int CNT_W      = 8,
   parameter int CODE_W     = 4,
   parameter int FULL_TICKS = 50
) (
   input  logic [CNT_W-1:0]  raw_i,
   output logic [CODE_W-1:0] code_o
);
   localparam int CODE_MAX = (1 << CODE_W) - 1;
   localparam int PW       = CNT_W + CODE_W;

   generate
      if (FULL_TICKS == CODE_MAX) begin : g_direct
         logic [PW-1:0] wide;
         assign wide   = PW'(raw_i);
         assign code_o = (wide > PW'(CODE_MAX)) ? CODE_W'(CODE_MAX) : wide[CODE_W-1:0];
      end else begin : g_ratio
         logic [PW-1:0] prod;
         logic [PW-1:0] quo;
         assign prod   = PW'(raw_i) * PW'(CODE_MAX);
         assign quo    = prod / PW'(FULL_TICKS);
         assign code_o = (quo > PW'(CODE_MAX)) ? CODE_W'(CODE_MAX) : quo[CODE_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/ramp_seq.sv
module ramp_seq
   import ramp_conv_pkg::*;
#(
   parameter int DISCH_CYCLES = 6,
   parameter int CNT_W        = 8,
   parameter int FULL_TICKS   = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             rise_i,
   input  logic [CNT_W-1:0] tick_i,
   output conv_state_t      state_o,
   output logic             capture_o,
   output logic             timeout_o
);
   localparam int DW = $clog2(DISCH_CYCLES + 1);
   localparam logic [DW-1:0]    D_LAST = DW'(DISCH_CYCLES - 1);
   localparam logic [CNT_W-1:0] T_FULL = CNT_W'(FULL_TICKS);

   conv_state_t   state_q, state_d;
   logic [DW-1:0] dcnt_q, dcnt_d;
   logic          at_full;

   assign at_full   = (tick_i == T_FULL);
   assign capture_o = (state_q == ST_RAMP) && (rise_i || at_full);
   assign timeout_o = (state_q == ST_RAMP) && !rise_i && at_full;

   always_comb begin
      state_d = state_q;
      dcnt_d  = dcnt_q;
      unique case (state_q)
         ST_IDLE: begin
            dcnt_d = '0;
            if (start_i) state_d = ST_DISCH;
         end
         ST_DISCH: begin
            if (dcnt_q == D_LAST) begin
               state_d = ST_RAMP;
               dcnt_d  = '0;
            end else begin
               dcnt_d = dcnt_q + 1'b1;
            end
         end
         ST_RAMP: begin
            if (capture_o) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dcnt_q  <= '0;
      end else begin
         state_q <= state_d;
         dcnt_q  <= dcnt_d;
      end
   end

   assign state_o = state_q;
endmodule

// File: rtl/ramp_conv_ctrl.sv
module ramp_conv_ctrl
   import ramp_conv_pkg::*;
#(
   parameter int CODE_W       = 4,
   parameter int CNT_W        = 8,
   parameter int FULL_TICKS   = 50,
   parameter int DISCH_CYCLES = 6,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cmp_i,
   output logic              discharge_o,
   output logic              ramp_en_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [CODE_W-1:0] code_o,
   output logic [CNT_W-1:0]  raw_o,
   output logic              overrange_o
);
   generate
      if (CODE_W < 1) begin : g_bad_code
         $error("CODE_W must be at least 1");
      end
      if (FULL_TICKS < 1 || FULL_TICKS >= (1 << CNT_W)) begin : g_bad_full
         $error("FULL_TICKS must lie in 1 .. 2**CNT_W-1");
      end
      if (DISCH_CYCLES < 1) begin : g_bad_disch
         $error("DISCH_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   conv_state_t       state;
   logic              cmp_level, cmp_rise;
   logic              capture, timeout;
   logic [CNT_W-1:0]  tick;
   logic [CODE_W-1:0] scaled;

   logic              done_q, over_q;
   logic [CODE_W-1:0] code_q;
   logic [CNT_W-1:0]  raw_q;

   ramp_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (cmp_i),
      .level_o (cmp_level),
      .rise_o  (cmp_rise)
   );

   ramp_seq #(
      .DISCH_CYCLES (DISCH_CYCLES),
      .CNT_W        (CNT_W),
      .FULL_TICKS   (FULL_TICKS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .rise_i    (cmp_rise),
      .tick_i    (tick),
      .state_o   (state),
      .capture_o (capture),
      .timeout_o (timeout)
   );

   ramp_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (state == ST_DISCH),
      .en_i    ((state == ST_RAMP) && !capture),
      .cnt_o   (tick)
   );

   ramp_code_scale #(
      .CNT_W      (CNT_W),
      .CODE_W     (CODE_W),
      .FULL_TICKS (FULL_TICKS)
   ) u_scale (
      .raw_i  (tick),
      .code_o (scaled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         over_q <= 1'b0;
         code_q <= '0;
         raw_q  <= '0;
      end else begin
         done_q <= capture;
         if (capture) begin
            raw_q  <= tick;
            over_q <= timeout;
            code_q <= timeout ? '1 : scaled;
         end
      end
   end

   logic unused_level;
   assign unused_level = cmp_level;

   assign discharge_o = (state != ST_RAMP);
   assign ramp_en_o   = (state == ST_RAMP);
   assign busy_o      = (state != ST_IDLE);
   assign done_o      = done_q;
   assign code_o      = code_q;
   assign raw_o       = raw_q;
   assign overrange_o = over_q;
endmodule

// File: rtl/ramp_conv_chk.sv
module ramp_conv_chk #(
   parameter int CODE_W       = 4,
   parameter int CNT_W        = 8,
   parameter int FULL_TICKS   = 50,
   parameter int DISCH_CYCLES = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              discharge_o,
   input logic              ramp_en_o,
   input logic              busy_o,
   input logic              done_o,
   input logic [CODE_W-1:0] code_o,
   input logic [CNT_W-1:0]  raw_o,
   input logic              overrange_o
);
   localparam int RW = $clog2(FULL_TICKS + 3);
   localparam int DW = $clog2(DISCH_CYCLES + 2);

   logic [RW-1:0] ramp_len;
   logic [DW-1:0] disch_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ramp_len <= '0;
      else if (!ramp_en_o) ramp_len <= '0;
      else if (ramp_len != '1) ramp_len <= ramp_len + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       disch_len <= '0;
      else if (!busy_o) disch_len <= '0;
      else if (discharge_o && disch_len != '1) disch_len <= disch_len + 1'b1;
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> !busy_o && discharge_o); // R7
   AST_RELEASE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ramp_en_o) |-> $fell(discharge_o)); // R3
   AST_DISCH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ramp_en_o) |-> disch_len == DW'(DISCH_CYCLES)); // R2
   AST_RAMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_en_o |-> ramp_len <= RW'(FULL_TICKS)); // R6
   AST_OVR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      overrange_o |-> (code_o == '1) && (raw_o == CNT_W'(FULL_TICKS))); // R6
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(code_o) && $stable(raw_o) && $stable(overrange_o)); // R8
endmodule

bind ramp_conv_ctrl ramp_conv_chk #(
   .CODE_W       (CODE_W),
   .CNT_W        (CNT_W),
   .FULL_TICKS   (FULL_TICKS),
   .DISCH_CYCLES (DISCH_CYCLES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .discharge_o (discharge_o),
   .ramp_en_o   (ramp_en_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .code_o      (code_o),
   .raw_o       (raw_o),
   .overrange_o (overrange_o)
);

// File: tb/tb_ramp_conv_ctrl.sv
module tb_ramp_conv_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int CODE_W = 4;
   localparam int CNT_W  = 8;
   localparam int FULL   = 50;
   localparam int DISCH  = 6;
   localparam int SYNC   = 2;
   localparam int WATCHDOG = 100000;

   // {input in mV, expected raw ticks, expected code}; 5000 mV = FULL ticks
   localparam int NVEC = 9;
   localparam int TBL [NVEC][3] = '{
      '{2500, 25,  7},
      '{ 500,  5,  1},
      '{1000, 10,  3},
      '{4000, 40, 12},
      '{3300, 33,  9},
      '{4900, 49, 14},
      '{ 200,  2,  0},
      '{5000, 50, 15},
      '{1700, 17,  5}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic cmp_i = 1'b0;
   logic discharge_o, ramp_en_o, busy_o, done_o, overrange_o;
   logic [CODE_W-1:0] code_o;
   logic [CNT_W-1:0]  raw_o;

   int n_run = 0;
   int n_fail = 0;
   int cycles = 0;
   bit finished = 1'b0;

   ramp_conv_ctrl #(
      .CODE_W(CODE_W), .CNT_W(CNT_W), .FULL_TICKS(FULL),
      .DISCH_CYCLES(DISCH), .SYNC_STAGES(SYNC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
      .discharge_o(discharge_o), .ramp_en_o(ramp_en_o), .busy_o(busy_o),
      .done_o(done_o), .code_o(code_o), .raw_o(raw_o), .overrange_o(overrange_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG && !finished) begin
         finished = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog act=%0d exp=%0d", cycles, WATCHDOG);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // One conversion. m < 0 means the comparator never rises.
   task automatic run_conv(input int m, input bit start_mid, input bit cmp_glitch,
                           output int dlen, output bit rel_ok, output int dwid,
                           output int held_code, output int ndone);
      int guard;
      dlen = 0; dwid = 0; ndone = 0; held_code = -1; rel_ok = 1'b0;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      guard = 0;
      while (!ramp_en_o && guard < 100) begin
         if (discharge_o && busy_o) dlen++;
         cmp_i   = cmp_glitch && (dlen == 1);
         start_i = start_mid && (dlen == 2);
         if (done_o) ndone++;
         @(negedge clk);
         guard++;
      end
      cmp_i = 1'b0; start_i = 1'b0;
      rel_ok = ramp_en_o && !discharge_o;
      for (int k = 0; k < 200; k++) begin
         if (done_o) break;
         if (k == m) cmp_i = 1'b1;
         start_i = start_mid && (k == 3);
         if (k == 1) held_code = int'(code_o);
         @(negedge clk);
      end
      start_i = 1'b0;
      if (done_o) begin
         ndone++;
         dwid = 1;
      end
      chk(!busy_o && discharge_o && !ramp_en_o, "R7 idle at done", int'(busy_o), 0);
      @(negedge clk);
      cmp_i = 1'b0;
      if (done_o) dwid++;
      for (int k = 0; k < 10; k++) begin
         if (done_o || busy_o) ndone++;
         @(negedge clk);
      end
   endtask

   initial begin : main
      int dlen, dwid, held, nd, prev_code;
      bit rel;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(discharge_o == 1'b1, "R1 discharge", int'(discharge_o), 1);
      chk(!ramp_en_o && !busy_o && !done_o, "R1 ramp/busy/done", int'(ramp_en_o), 0);
      chk(code_o == 0 && raw_o == 0 && !overrange_o, "R1 result", int'(raw_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R10: comparator edge while idle is ignored
      cmp_i = 1'b1;
      repeat (5) @(negedge clk);
      chk(!done_o && !busy_o && raw_o == 0, "R10 idle cmp", int'(busy_o), 0);
      cmp_i = 1'b0;
      repeat (4) @(negedge clk);

      prev_code = 0;
      for (int i = 0; i < NVEC; i++) begin
         run_conv(TBL[i][1] - SYNC, 1'b0, 1'b0, dlen, rel, dwid, held, nd);
         chk(int'(raw_o) == TBL[i][1], "R4 raw count", int'(raw_o), TBL[i][1]);
         chk(int'(code_o) == TBL[i][2], "R5 scaled code", int'(code_o), TBL[i][2]);
         chk(!overrange_o, "R5 no overrange", int'(overrange_o), 0);
         chk(dlen == DISCH, "R2 discharge length", dlen, DISCH);
         chk(rel, "R3 same-edge release", int'(rel), 1);
         chk(dwid == 1, "R7 done width", dwid, 1);
         chk(held == prev_code, "R8 hold during next conversion", held, prev_code);
         prev_code = TBL[i][2];
      end

      // R6: no comparator edge -> timeout
      run_conv(-1, 1'b0, 1'b0, dlen, rel, dwid, held, nd);
      chk(int'(raw_o) == FULL && overrange_o, "R6 timeout raw", int'(raw_o), FULL);
      chk(int'(code_o) == 15, "R6 timeout code", int'(code_o), 15);
      // R6: crossing one tick past full scale still times out
      run_conv(FULL - SYNC + 1, 1'b0, 1'b0, dlen, rel, dwid, held, nd);
      chk(overrange_o == 1'b1, "R6 late crossing overrange", int'(overrange_o), 1);
      chk(int'(raw_o) == FULL, "R6 late crossing raw", int'(raw_o), FULL);
      // R6: crossing exactly at full scale beats the timeout
      run_conv(FULL - SYNC, 1'b0, 1'b0, dlen, rel, dwid, held, nd);
      chk(!overrange_o && int'(code_o) == 15, "R6 exact full scale", int'(overrange_o), 0);

      // R9: start during discharge and during ramp ignored
      run_conv(20 - SYNC, 1'b1, 1'b0, dlen, rel, dwid, held, nd);
      chk(int'(raw_o) == 20, "R9 start while busy raw", int'(raw_o), 20);
      chk(int'(code_o) == 6, "R9 start while busy code", int'(code_o), 6);
      chk(nd == 1, "R9 single done", nd, 1);
      chk(dlen == DISCH, "R9 discharge not restarted", dlen, DISCH);

      // R10: comparator glitch during discharge ignored
      run_conv(30 - SYNC, 1'b0, 1'b1, dlen, rel, dwid, held, nd);
      chk(int'(raw_o) == 30, "R10 glitch in discharge raw", int'(raw_o), 30);
      chk(int'(code_o) == 9, "R10 glitch in discharge code", int'(code_o), 9);

      // R1: asynchronous reset mid-conversion restores reset state
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!busy_o && discharge_o && raw_o == 0 && code_o == 0, "R1 reset mid-run",
          int'(busy_o), 0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule